// File: doc/BRIEF.md
# Ingress Bus Word Parser and Protocol Checker

This block sits directly behind the receive side of a packet-over-parallel-bus interface. It takes one 16-bit bus word per valid cycle together with a control flag. From the flag and the control-field bits, it decides whether the word is payload data, a payload control word, an idle control word, a training word or a reserved code. A payload control word opens a transfer for a logical port. The data words after it are forwarded with that port's local ID, taken from a small programmable mapping table. Each forwarded word carries start, end, abort, error and byte-length tags.

Protocol violations produce one-cycle event pulses, and each has its own recovery. Reserved codes are dropped. Of back-to-back payload control words, only the last one takes effect. Orphan data is dropped. An unaligned burst is flagged. Traffic to an inactive port is discarded. The DIP-4 arithmetic is done outside the block and arrives as an error strobe. The block turns that strobe into an event and tags the packet that is still open. When a transfer closes, it reports a byte total for statistics.

Top module: `ipc_ingress_parser`

## Requirements
- R1: With `rx_ctl`=0 a word is data. With `rx_ctl`=1 the word is split as follows: bit 15 set marks a payload control word, with bits 14:13 the end status, bit 12 the start flag and bits 11:4 the port. The exact value 16'h0FFF is a training control word. Other words with bit 15 clear and bits 12:4 zero are idle, with bits 14:13 giving the end status. Every other control code is reserved.
- R2: Each data word accepted for an active port is output with the local ID mapped from the port of the most recent effective payload control word. `out_sop` is set only on the first word after a control word whose start flag was 1.
- R3: A data word is output one cycle after the next word that decides its fate arrives (a data word for the same active port, or a payload, idle or training control word). The end status of the closing control word sets the tags: 00 means no end, `out_len`=2. 01 means end with abort, `out_len`=2. 10 means end, `out_len`=2. 11 means end, `out_len`=1. A word released by a data word always has `out_eop`=0 and `out_len`=2.
- R4: A reserved control word pulses `ev_bus_err` and changes no state. An open transfer continues through it.
- R5: Two payload control words with no data between them pulse `ev_bus_err` on the second one, and the second one's port and start flag take effect.
- R6: A data word that arrives with no open transfer (after idle, or from reset) pulses `ev_bus_err` and is dropped. Data after a training control word is discarded silently.
- R7: A payload control word that names an inactive or out-of-range port pulses `ev_inactive`. Its data words are dropped and produce no statistics.
- R8: A payload, idle or training control word that closes an open transfer with end status 00, after a word count that is not a multiple of BURST_WORDS, pulses `ev_bus_err`.
- R9: `rx_dip_err` on a non-data word while in sync pulses `ev_dip`. Every word emitted from then on is tagged with `out_err`, up to and including the next word emitted with `out_eop`.
- R10: A mapping write is rejected, leaving the table unchanged and setting the sticky `cfg_err`, if it comes while `in_sync`=1, names an out-of-range port, or activates a local ID already held by another active port.
- R11: When a control word closes an open transfer of an active port with at least one word, `stat_valid` pulses with `stat_bytes` = 2 × words − (1 if end status is 11).
- R12: While `in_sync`=0 nothing is forwarded, no event pulses, and all transfer state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_sync | input | 1 | Receive link is in sync |
| rx_valid | input | 1 | Bus word present this cycle |
| rx_ctl | input | 1 | Word is a control word |
| rx_word | input | 16 | Bus word |
| rx_dip_err | input | 1 | External DIP-4 check failed for this control word |
| map_we | input | 1 | Mapping table write strobe |
| map_lp | input | 8 | Port to map |
| map_lid | input | LID_W | Local ID to assign |
| map_active | input | 1 | Port active flag to write |
| out_valid | output | 1 | Tagged word valid |
| out_data | output | 16 | Forwarded data word |
| out_sop | output | 1 | First word of packet |
| out_eop | output | 1 | Last word of packet |
| out_abort | output | 1 | Packet ended with abort |
| out_err | output | 1 | Packet has a DIP error |
| out_len | output | 2 | Valid bytes in word (1 or 2) |
| out_lid | output | LID_W | Local ID of word |
| ev_bus_err | output | 1 | Protocol violation pulse |
| ev_inactive | output | 1 | Transfer to inactive port pulse |
| ev_dip | output | 1 | DIP error pulse |
| stat_valid | output | 1 | Transfer closed, byte count valid |
| stat_bytes | output | STAT_W | Bytes in the closed transfer |
| cfg_err | output | 1 | Sticky rejected mapping write |

## Verification
The hardest cases involve the alignment rule and the end tags together. The end of a word is only known when the next control word arrives. Whether that closing word raises an alignment error depends on both the burst length and its end status. The bench sweeps every burst length from one to two bursts against all four end statuses, and works out the tags, the alignment outcome and the byte count for each case arithmetically. The DIP tag has to survive a control word in the middle of a packet and then clear at the end. This is reached by a control word carrying the error strobe that closes an aligned burst without an end, followed by more data and an ending idle.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
   localparam int WORD_W = 16;
   localparam int PORT_W = 8;
   localparam logic [WORD_W-1:0] TRAIN_CODE = 16'h0FFF;

   typedef enum logic [2:0] {
      WK_DATA, WK_PCTL, WK_IDLE, WK_TRAIN, WK_RSVD
   } word_kind_e;

   typedef enum logic [1:0] {
      ES_NONE  = 2'b00,
      ES_ABORT = 2'b01,
      ES_TWO   = 2'b10,
      ES_ONE   = 2'b11
   } end_st_e;

   typedef struct packed {
      end_st_e            est;
      logic               sop;
      logic [PORT_W-1:0]  port;
   } ctl_fields_t;
endpackage

// File: rtl/ipc_word_classify.sv
module ipc_word_classify
   import ipc_pkg::*;
(
   input  logic              ctl,
   input  logic [WORD_W-1:0] word,
   output word_kind_e        kind,
   output ctl_fields_t       fields
);
   logic idle_shape;

   always_comb begin
      fields.est  = end_st_e'(word[14:13]);
      fields.sop  = word[12];
      fields.port = word[11:4];
   end

   assign idle_shape = (word[12:4] == '0);

   always_comb begin
      if (!ctl)
         kind = WK_DATA;
      else if (word[15])
         kind = WK_PCTL;
      else if (word == TRAIN_CODE)
         kind = WK_TRAIN;
      else if (idle_shape)
         kind = WK_IDLE;
      else
         kind = WK_RSVD;
   end
endmodule

// File: rtl/ipc_lid_map.sv
module ipc_lid_map
   import ipc_pkg::*;
#(
   parameter int NUM_LP = 16,
   parameter int LID_W  = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_sync,
   input  logic              wr_en,
   input  logic [PORT_W-1:0] wr_lp,
   input  logic [LID_W-1:0]  wr_lid,
   input  logic              wr_act,
   input  logic [PORT_W-1:0] rd_lp,
   output logic              rd_act,
   output logic [LID_W-1:0]  rd_lid,
   output logic              cfg_err
);
   logic             act_q [NUM_LP];
   logic [LID_W-1:0] lid_q [NUM_LP];
   logic [NUM_LP-1:0] clash;
   logic [NUM_LP-1:0] act_vec;
   logic [NUM_LP*LID_W-1:0] lid_vec;
   logic lp_range_bad, reject, accept, cfg_err_q;

   assign lp_range_bad = (int'(wr_lp) >= NUM_LP);
   assign reject = in_sync || lp_range_bad || (wr_act && (|clash));
   assign accept = wr_en && !reject;

   for (genvar i = 0; i < NUM_LP; i++) begin : g_entry
      assign clash[i] = act_q[i] && (lid_q[i] == wr_lid) && (wr_lp != PORT_W'(i));
      assign act_vec[i] = act_q[i];
      assign lid_vec[i*LID_W +: LID_W] = lid_q[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            act_q[i] <= 1'b0;
            lid_q[i] <= '0;
         end else if (accept && (wr_lp == PORT_W'(i))) begin
            act_q[i] <= wr_act;
            lid_q[i] <= wr_lid;
         end
      end
   end

   always_comb begin
      rd_act = 1'b0;
      rd_lid = '0;
      for (int i = 0; i < NUM_LP; i++) begin
         if (rd_lp == PORT_W'(i)) begin
            rd_act = act_q[i];
            rd_lid = lid_q[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_err_q <= 1'b0;
      else        cfg_err_q <= cfg_err_q | (wr_en && reject);
   end
   assign cfg_err = cfg_err_q;

   // R10: the table is frozen while the link stays in sync
   p_frozen_in_sync_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_sync && $past(in_sync)) |-> ($stable(act_vec) && $stable(lid_vec)));
   // R10: a rejected write leaves a lasting flag
   p_cfg_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_err) |-> cfg_err);
endmodule

// File: rtl/ipc_xfer_track.sv
module ipc_xfer_track
   import ipc_pkg::*;
#(
   parameter int LID_W       = 4,
   parameter int BURST_WORDS = 8,
   parameter int STAT_W      = 16,
   parameter bit CHECK_ALIGN = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_sync,
   input  logic              rx_valid,
   input  logic [WORD_W-1:0] rx_word,
   input  logic              rx_dip_err,
   input  word_kind_e        kind,
   input  ctl_fields_t       fields,
   input  logic              rd_act,
   input  logic [LID_W-1:0]  rd_lid,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_data,
   output logic              out_sop,
   output logic              out_eop,
   output logic              out_abort,
   output logic              out_err,
   output logic [1:0]        out_len,
   output logic [LID_W-1:0]  out_lid,
   output logic              ev_bus_err,
   output logic              ev_inactive,
   output logic              ev_dip,
   output logic              stat_valid,
   output logic [STAT_W-1:0] stat_bytes
);
   localparam int CNT_W = $clog2(BURST_WORDS);
   localparam int WRD_W = STAT_W - 1;

   logic              open_q, act_q, sop_q, prev_pctl_q, train_q, err_q;
   logic [LID_W-1:0]  lid_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [WRD_W-1:0]  words_q;
   logic              pend_q, pend_sop_q;
   logic [WORD_W-1:0] pend_data_q;
   logic [LID_W-1:0]  pend_lid_q;

   logic    live, closing, is_data, fwd, emit, emit_eop, dip_c, err_now;
   logic    orphan, b2b, rsvd, unalign, bus_err_c;
   end_st_e est;

   assign live     = rx_valid && in_sync;
   assign closing  = live && (kind == WK_PCTL || kind == WK_IDLE || kind == WK_TRAIN);
   assign est      = (kind == WK_TRAIN) ? ES_NONE : fields.est;
   assign is_data  = live && (kind == WK_DATA);
   assign fwd      = is_data && !train_q && open_q && act_q;
   assign emit     = pend_q && (closing || fwd);
   assign emit_eop = closing && (est != ES_NONE);
   assign dip_c    = live && (kind != WK_DATA) && rx_dip_err;
   assign err_now  = err_q | dip_c;
   assign orphan   = is_data && !train_q && !open_q;
   assign b2b      = live && (kind == WK_PCTL) && prev_pctl_q;
   assign rsvd     = live && (kind == WK_RSVD);

   if (CHECK_ALIGN) begin : g_align_chk
      assign unalign = closing && open_q && (cnt_q != '0) && (est == ES_NONE);
   end else begin : g_align_off
      assign unalign = 1'b0;
   end

   assign bus_err_c = rsvd | b2b | orphan | unalign;

   // event and output stage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_data    <= '0;
         out_sop     <= 1'b0;
         out_eop     <= 1'b0;
         out_abort   <= 1'b0;
         out_err     <= 1'b0;
         out_len     <= 2'd0;
         out_lid     <= '0;
         ev_bus_err  <= 1'b0;
         ev_inactive <= 1'b0;
         ev_dip      <= 1'b0;
         stat_valid  <= 1'b0;
         stat_bytes  <= '0;
      end else begin
         out_valid <= emit;
         if (emit) begin
            out_data  <= pend_data_q;
            out_sop   <= pend_sop_q;
            out_lid   <= pend_lid_q;
            out_eop   <= emit_eop;
            out_abort <= emit_eop && (est == ES_ABORT);
            out_len   <= (emit_eop && est == ES_ONE) ? 2'd1 : 2'd2;
            out_err   <= err_now;
         end
         ev_bus_err  <= bus_err_c;
         ev_inactive <= live && (kind == WK_PCTL) && !rd_act;
         ev_dip      <= dip_c;
         stat_valid  <= closing && open_q && act_q && (words_q != '0);
         stat_bytes  <= {words_q, 1'b0} - STAT_W'((est == ES_ONE) ? 1 : 0);
      end
   end

   // transfer state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q      <= 1'b0;
         act_q       <= 1'b0;
         sop_q       <= 1'b0;
         prev_pctl_q <= 1'b0;
         train_q     <= 1'b0;
         err_q       <= 1'b0;
         lid_q       <= '0;
         cnt_q       <= '0;
         words_q     <= '0;
      end else if (!in_sync) begin
         open_q      <= 1'b0;
         prev_pctl_q <= 1'b0;
         train_q     <= 1'b0;
         err_q       <= 1'b0;
      end else if (rx_valid) begin
         err_q <= err_now & ~(emit && emit_eop);
         case (kind)
            WK_PCTL: begin
               open_q      <= 1'b1;
               act_q       <= rd_act;
               lid_q       <= rd_lid;
               sop_q       <= fields.sop;
               cnt_q       <= '0;
               words_q     <= '0;
               prev_pctl_q <= 1'b1;
               train_q     <= 1'b0;
            end
            WK_IDLE: begin
               open_q      <= 1'b0;
               prev_pctl_q <= 1'b0;
               train_q     <= 1'b0;
            end
            WK_TRAIN: begin
               open_q      <= 1'b0;
               prev_pctl_q <= 1'b0;
               train_q     <= 1'b1;
            end
            WK_DATA: begin
               prev_pctl_q <= 1'b0;
               if (!train_q && open_q) begin
                  cnt_q   <= cnt_q + 1'b1;
                  words_q <= words_q + 1'b1;
                  if (act_q) sop_q <= 1'b0;
               end
            end
            default: ;
         endcase
      end
   end

   // one-word holding register: the end tag is only known from the next word
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q      <= 1'b0;
         pend_sop_q  <= 1'b0;
         pend_data_q <= '0;
         pend_lid_q  <= '0;
      end else if (!in_sync) begin
         pend_q <= 1'b0;
      end else if (fwd) begin
         pend_q      <= 1'b1;
         pend_sop_q  <= sop_q;
         pend_data_q <= rx_word;
         pend_lid_q  <= lid_q;
      end else if (emit) begin
         pend_q <= 1'b0;
      end
   end

   // R3: abort only on an ending word
   p_abort_needs_eop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_abort) |-> out_eop);
   // R3: a word that does not end a packet is full width
   p_mid_len_two_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_eop) |-> (out_len == 2'd2));
   // R12: out of sync means quiet outputs
   p_quiet_unsync_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(in_sync) |-> (!out_valid && !ev_bus_err && !ev_dip && !stat_valid));
   // R11: a reported transfer always has bytes
   p_stat_nonzero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      stat_valid |-> (stat_bytes != '0));
   // R7: nothing is forwarded from an inactive port
   p_inactive_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (open_q && !act_q && $past(open_q) && !$past(act_q)) |-> !out_valid);
endmodule

// File: rtl/ipc_ingress_parser.sv
module ipc_ingress_parser
   import ipc_pkg::*;
#(
   parameter int NUM_LP      = 16,
   parameter int LID_W       = 4,
   parameter int BURST_WORDS = 8,
   parameter int STAT_W      = 16,
   parameter bit CHECK_ALIGN = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_sync,
   input  logic              rx_valid,
   input  logic              rx_ctl,
   input  logic [15:0]       rx_word,
   input  logic              rx_dip_err,
   input  logic              map_we,
   input  logic [7:0]        map_lp,
   input  logic [LID_W-1:0]  map_lid,
   input  logic              map_active,
   output logic              out_valid,
   output logic [15:0]       out_data,
   output logic              out_sop,
   output logic              out_eop,
   output logic              out_abort,
   output logic              out_err,
   output logic [1:0]        out_len,
   output logic [LID_W-1:0]  out_lid,
   output logic              ev_bus_err,
   output logic              ev_inactive,
   output logic              ev_dip,
   output logic              stat_valid,
   output logic [STAT_W-1:0] stat_bytes,
   output logic              cfg_err
);
   if (NUM_LP < 1 || NUM_LP > 256) begin : g_bad_lp
      $error("NUM_LP must lie in 1..256");
   end
   if (LID_W < 1 || (1 << LID_W) < 1) begin : g_bad_lid
      $error("LID_W must be at least 1");
   end
   if (BURST_WORDS < 2 || (BURST_WORDS & (BURST_WORDS - 1)) != 0) begin : g_bad_burst
      $error("BURST_WORDS must be a power of two of at least 2");
   end
   if (STAT_W < 4) begin : g_bad_stat
      $error("STAT_W must be at least 4");
   end

   word_kind_e  kind;
   ctl_fields_t fields;
   logic        rd_act;
   logic [LID_W-1:0] rd_lid;

   ipc_word_classify u_classify (
      .ctl    (rx_ctl),
      .word   (rx_word),
      .kind   (kind),
      .fields (fields)
   );

   ipc_lid_map #(.NUM_LP(NUM_LP), .LID_W(LID_W)) u_map (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_sync (in_sync),
      .wr_en   (map_we),
      .wr_lp   (map_lp),
      .wr_lid  (map_lid),
      .wr_act  (map_active),
      .rd_lp   (fields.port),
      .rd_act  (rd_act),
      .rd_lid  (rd_lid),
      .cfg_err (cfg_err)
   );

   ipc_xfer_track #(
      .LID_W(LID_W), .BURST_WORDS(BURST_WORDS),
      .STAT_W(STAT_W), .CHECK_ALIGN(CHECK_ALIGN)
   ) u_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_sync     (in_sync),
      .rx_valid    (rx_valid),
      .rx_word     (rx_word),
      .rx_dip_err  (rx_dip_err),
      .kind        (kind),
      .fields      (fields),
      .rd_act      (rd_act),
      .rd_lid      (rd_lid),
      .out_valid   (out_valid),
      .out_data    (out_data),
      .out_sop     (out_sop),
      .out_eop     (out_eop),
      .out_abort   (out_abort),
      .out_err     (out_err),
      .out_len     (out_len),
      .out_lid     (out_lid),
      .ev_bus_err  (ev_bus_err),
      .ev_inactive (ev_inactive),
      .ev_dip      (ev_dip),
      .stat_valid  (stat_valid),
      .stat_bytes  (stat_bytes)
   );
endmodule

// File: tb/ipc_ingress_parser_tb.sv
module ipc_ingress_parser_tb_top;
   localparam int NLP = 4;
   localparam int LW  = 2;
   localparam int BW  = 4;
   localparam int SW  = 16;

   logic clk = 1'b0, rst_n = 1'b0, in_sync = 1'b0;
   logic rx_valid = 1'b0, rx_ctl = 1'b0, rx_dip_err = 1'b0;
   logic [15:0] rx_word = '0;
   logic map_we = 1'b0, map_active = 1'b0;
   logic [7:0] map_lp = '0;
   logic [LW-1:0] map_lid = '0;
   logic out_valid, out_sop, out_eop, out_abort, out_err;
   logic [15:0] out_data;
   logic [1:0] out_len;
   logic [LW-1:0] out_lid;
   logic ev_bus_err, ev_inactive, ev_dip, stat_valid, cfg_err;
   logic [SW-1:0] stat_bytes;

   int errs = 0, checks = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   ipc_ingress_parser #(.NUM_LP(NLP), .LID_W(LW), .BURST_WORDS(BW), .STAT_W(SW)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_sync(in_sync),
      .rx_valid(rx_valid), .rx_ctl(rx_ctl), .rx_word(rx_word), .rx_dip_err(rx_dip_err),
      .map_we(map_we), .map_lp(map_lp), .map_lid(map_lid), .map_active(map_active),
      .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
      .out_abort(out_abort), .out_err(out_err), .out_len(out_len), .out_lid(out_lid),
      .ev_bus_err(ev_bus_err), .ev_inactive(ev_inactive), .ev_dip(ev_dip),
      .stat_valid(stat_valid), .stat_bytes(stat_bytes), .cfg_err(cfg_err));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [15:0] pctl(input int lp, input bit sop, input int e);
      return {1'b1, 2'(e), sop, 8'(lp), 4'h0};
   endfunction
   function automatic logic [15:0] idle(input int e);
      return {1'b0, 2'(e), 1'b0, 8'h00, 4'h0};
   endfunction
   function automatic logic [15:0] dword(input int n, input int e, input int k);
      return 16'(n * 256 + e * 32 + k + 1);
   endfunction

   // drive one word, return after outputs of that edge are visible
   task automatic put(input bit c, input logic [15:0] w, input bit d);
      @(negedge clk);
      rx_valid = 1'b1; rx_ctl = c; rx_word = w; rx_dip_err = d;
      @(negedge clk);
      rx_valid = 1'b0; rx_dip_err = 1'b0;
   endtask

   task automatic mapw(input int lp, input int lid, input bit act);
      @(negedge clk);
      map_we = 1'b1; map_lp = 8'(lp); map_lid = LW'(lid); map_active = act;
      @(negedge clk);
      map_we = 1'b0;
   endtask

   task automatic quiet(input string req);
      chk(!out_valid, req, out_valid, 0);
      chk(!ev_bus_err, req, ev_bus_err, 0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errs++; checks++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!out_valid && !cfg_err && !stat_valid, "R12 reset state", out_valid, 0);
      rst_n = 1'b1;

      mapw(0, 2, 1); mapw(1, 1, 1); mapw(3, 0, 1);
      chk(!cfg_err, "R10 legal writes", cfg_err, 0);
      mapw(2, 2, 1); // duplicate local ID
      chk(cfg_err, "R10 duplicate rejected", cfg_err, 1);
      mapw(9, 3, 1); // out of range port, flag stays set
      chk(cfg_err, "R10 sticky", cfg_err, 1);

      // R12: traffic while out of sync is dropped
      put(1, pctl(0, 1, 0), 1'b1);
      chk(!ev_dip && !ev_inactive, "R12 no events unsync", ev_dip, 0);
      put(0, 16'h1234, 1'b0); quiet("R12 data unsync");
      put(1, idle(2), 1'b0);  quiet("R12 close unsync");
      chk(!stat_valid, "R12 no stats unsync", stat_valid, 0);

      @(negedge clk); in_sync = 1'b1;
      mapw(0, 3, 1); // rejected: in sync, lp0 keeps local ID 2
      chk(cfg_err, "R10 write in sync", cfg_err, 1);

      // R1 R2 R3 R8 R11: sweep burst lengths against end statuses
      put(1, idle(0), 1'b0);
      for (int n = 1; n <= 2 * BW; n++) begin
         for (int e = 0; e < 4; e++) begin
            int lp, lid;
            lp  = (n % 2 == 1) ? 1 : 0;
            lid = (lp == 1) ? 1 : 2;
            put(1, pctl(lp, 1, 0), 1'b0);
            chk(!ev_bus_err && !ev_inactive, "R5 single control word", ev_bus_err, 0);
            for (int k = 0; k < n; k++) begin
               put(0, dword(n, e, k), 1'b0);
               if (k == 0) chk(!out_valid, "R3 first word held", out_valid, 0);
               else begin
                  chk(out_valid && out_data == dword(n, e, k - 1), "R2 data order", out_data, dword(n, e, k - 1));
                  chk(out_sop == (k == 1), "R2 sop only first", out_sop, k == 1);
                  chk(!out_eop && out_len == 2, "R3 mid word tags", out_len, 2);
                  chk(out_lid == LW'(lid), "R2 local ID", out_lid, lid);
               end
            end
            put(1, idle(e), 1'b0);
            chk(out_valid && out_data == dword(n, e, n - 1), "R3 last word released", out_data, dword(n, e, n - 1));
            chk(out_sop == (n == 1), "R2 sop single word", out_sop, n == 1);
            chk(out_eop == (e != 0), "R3 eop from end status", out_eop, e != 0);
            chk(out_abort == (e == 1), "R3 abort code", out_abort, e == 1);
            chk(out_len == ((e == 3) ? 1 : 2), "R3 byte length", out_len, (e == 3) ? 1 : 2);
            chk(!out_err, "R9 no error tag", out_err, 0);
            chk(ev_bus_err == ((n % BW != 0) && e == 0), "R8 alignment", ev_bus_err, (n % BW != 0) && e == 0);
            chk(stat_valid && stat_bytes == SW'(2 * n - ((e == 3) ? 1 : 0)), "R11 byte count",
                stat_bytes, 2 * n - ((e == 3) ? 1 : 0));
         end
      end

      // R5 and R7: inactive port then an overriding control word
      put(1, pctl(2, 1, 0), 1'b0);
      chk(ev_inactive && !ev_bus_err, "R7 inactive port event (R10 table unchanged)", ev_inactive, 1);
      put(1, pctl(3, 1, 0), 1'b0);
      chk(ev_bus_err && !ev_inactive, "R5 back-to-back error", ev_bus_err, 1);
      put(0, 16'hABCD, 1'b0); quiet("R5 data held");
      put(1, idle(2), 1'b0);
      chk(out_valid && out_data == 16'hABCD && out_lid == 0 && out_sop && out_eop, "R5 last control word wins", out_lid, 0);

      // R7: data of an inactive port dropped
      put(1, pctl(2, 1, 0), 1'b0);
      chk(ev_inactive, "R7 inactive event", ev_inactive, 1);
      put(0, 16'h1111, 1'b0); quiet("R7 dropped word");
      put(0, 16'h2222, 1'b0); quiet("R7 dropped word");
      put(1, idle(2), 1'b0);
      chk(!out_valid && !stat_valid, "R7 no output or stats", out_valid, 0);

      // R4: reserved control word inside a packet
      put(1, pctl(0, 1, 0), 1'b0);
      put(0, 16'h0A0A, 1'b0);
      put(1, 16'h0010, 1'b0);
      chk(ev_bus_err && !out_valid, "R4 reserved flagged and ignored", ev_bus_err, 1);
      put(0, 16'h0B0B, 1'b0);
      chk(out_valid && out_data == 16'h0A0A && !out_eop && out_sop, "R4 transfer continues", out_data, 16'h0A0A);
      put(1, idle(2), 1'b0);
      chk(out_valid && out_data == 16'h0B0B && out_eop && out_lid == 2, "R4 end after reserved", out_data, 16'h0B0B);

      // R6: data after idle
      put(1, idle(0), 1'b0);
      put(0, 16'h7777, 1'b0);
      chk(ev_bus_err && !out_valid, "R6 orphan data", ev_bus_err, 1);

      // R6: training words are not forwarded and not errors
      put(1, 16'h0FFF, 1'b0); quiet("R1 training control");
      put(0, 16'hF000, 1'b0); quiet("R6 training data");
      put(0, 16'hF000, 1'b0); quiet("R6 training data");
      put(1, idle(0), 1'b0);  quiet("R6 idle after training");

      // R9: DIP error mid packet tags until end
      put(1, pctl(0, 1, 0), 1'b0);
      for (int k = 0; k < BW; k++) put(0, 16'(16'h0C00 + k), 1'b0);
      put(1, pctl(0, 0, 0), 1'b1);
      chk(ev_dip && !ev_bus_err, "R9 dip event", ev_dip, 1);
      chk(out_valid && out_err && !out_eop && out_data == 16'h0C03, "R9 tag on released word", out_err, 1);
      put(0, 16'h0D00, 1'b0); quiet("R9 held word");
      put(1, idle(2), 1'b0);
      chk(out_valid && out_err && out_eop && !out_sop, "R9 tag until end", out_err, 1);
      put(1, pctl(0, 1, 0), 1'b0);
      put(0, 16'h0E00, 1'b0);
      put(1, idle(2), 1'b0);
      chk(out_valid && !out_err && !ev_dip, "R9 tag cleared", out_err, 0);

      // R12: losing sync clears the open transfer
      put(1, pctl(0, 1, 0), 1'b0);
      put(0, 16'h0F0F, 1'b0);
      @(negedge clk); in_sync = 1'b0;
      @(negedge clk); in_sync = 1'b1;
      put(0, 16'h0F10, 1'b0);
      chk(ev_bus_err && !out_valid, "R12 state cleared on sync loss", ev_bus_err, 1);

      finish_run();
   end
endmodule